// File: doc/BRIEF.md
# Fixed-Pole DC-Blocking High-Pass Filter

This block strips the residual DC offset from one channel of signed 24-bit audio. Each accepted sample passes through a first-order recursive section with a zero at DC and a fixed pole just inside the unit circle: y[n] = x[n] − x[n−1] + (1 − 2⁻¹¹)·y[n−1]. The pole value of about 0.99951 sets a corner frequency that is a fixed fraction of the sample rate, because the recursion advances only when a sample arrives.

The filter state is held at full precision with 8 fractional guard bits, so the 24-bit input path loses no resolution. The feedback leak is rounded away from zero, which lets a held constant input decay to exactly zero instead of stalling in a small limit cycle. The result is clamped to the signed 24-bit range. A static `invert` input negates the result for systems that need an inverted output phase. Several channels are handled by placing one instance per channel.

Top module: `dc_block_hpf`

## Requirements
- R1: While `rst` is high at a rising clock edge, the stored previous input and the filter accumulator are cleared to zero. In the following cycle `out_valid` is 0 and `out_data` is 0.
- R2: A sample is accepted on each rising edge where `in_valid` is 1. `out_valid` is 1 in exactly the cycle after an accepted sample and 0 in every other cycle. `out_data` keeps its value while no sample is accepted.
- R3: Each accepted sample x updates the accumulator A, which is a signed value with 8 fractional bits. The update is A ← A − L + (x − xp)·256, where xp is the previous accepted input and L is A/2048 rounded away from zero. With `invert` = 0, `out_data` is floor(A/256) of the updated A.
- R4: `out_data` saturates to the range −8388608…8388607 and does not wrap. For example, after reset, input 8388607 followed by −8388608 gives 8388607 and then −8388608.
- R5: With `invert` = 1, `out_data` is the saturated negation of the R3 result. An R3 result of −8388608 maps to 8388607.
- R6: Cycles with `in_valid` = 0 leave the filter state untouched. The next accepted sample yields the same result that it would give with no idle cycles in between.
- R7: Starting from reset, a constant input of ±1000 held for 20000 samples produces an output whose magnitude is at most 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| invert | input | 1 | 1 = negate the output |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 24 | Signed input sample |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | 24 | Signed filtered sample |

## Verification
The embedded assertions check the timing contract on every cycle. They confirm that a result strobe follows each accepted sample and nothing else, that the output stays still between results, and that reset leaves the output cleared. The numeric behaviour can only be shown by the bench's scenarios. This covers the exact fixed-point recursion, clamping at both rails, negation of the most negative value, state retention across idle gaps, and decay of a held input to zero over twenty thousand samples.

// File: rtl/dc_block_hpf.sv
module dc_block_hpf #(
  parameter int DATA_W     = 24,
  parameter int FRAC_W     = 8,
  parameter int POLE_SHIFT = 11
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     invert,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_data,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_data
);
  localparam int ACC_W = DATA_W + FRAC_W + 2;
  localparam int SUM_W = ACC_W + 2;
  localparam logic signed [SUM_W-1:0] ONE    = SUM_W'(1);
  localparam logic signed [SUM_W-1:0] RND    = (ONE <<< POLE_SHIFT) - ONE;
  localparam logic signed [SUM_W-1:0] ACC_HI = (ONE <<< (ACC_W-1)) - ONE;
  localparam logic signed [SUM_W-1:0] ACC_LO = -ACC_HI - ONE;
  localparam logic signed [SUM_W-1:0] OUT_HI = (ONE <<< (DATA_W-1)) - ONE;
  localparam logic signed [SUM_W-1:0] OUT_LO = -OUT_HI - ONE;

  logic signed [ACC_W-1:0]  acc_q;
  logic signed [DATA_W-1:0] xprev_q;
  logic signed [SUM_W-1:0]  acc_x, diff, leak, sum, acc_n, y_full, y_pol, y_sat;

  assign acc_x  = SUM_W'(acc_q);
  assign diff   = (SUM_W'(in_data) - SUM_W'(xprev_q)) <<< FRAC_W;
  // leak rounded away from zero so any nonzero state keeps decaying
  assign leak   = acc_x[SUM_W-1] ? (acc_x >>> POLE_SHIFT)
                                 : ((acc_x + RND) >>> POLE_SHIFT);
  assign sum    = acc_x - leak + diff;
  assign acc_n  = (sum > ACC_HI) ? ACC_HI : (sum < ACC_LO) ? ACC_LO : sum;
  assign y_full = acc_n >>> FRAC_W;
  assign y_pol  = invert ? -y_full : y_full;
  assign y_sat  = (y_pol > OUT_HI) ? OUT_HI : (y_pol < OUT_LO) ? OUT_LO : y_pol;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q     <= '0;
      xprev_q   <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        acc_q    <= acc_n[ACC_W-1:0];
        xprev_q  <= in_data;
        out_data <= y_sat[DATA_W-1:0];
      end
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0));

  assert_strobe_follows_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  assert_hold_when_idle_R6: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_data));
endmodule

// File: tb/dc_block_hpf_tb.sv
module dc_block_hpf_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  localparam logic signed [23:0] VEC_IN  [NVEC] = '{24'sd1000, 24'sd1000, 24'sd1000, 24'sd1000, 24'sd0, 24'sd0};
  localparam logic signed [23:0] VEC_EXP [NVEC] = '{24'sd1000, 24'sd999, 24'sd999, 24'sd998, -24'sd2, -24'sd2};

  logic clk = 1'b0, rst = 1'b1, invert = 1'b0, in_valid = 1'b0;
  logic signed [23:0] in_data = '0;
  logic out_valid;
  logic signed [23:0] out_data;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  dc_block_hpf u_dut (.clk(clk), .rst(rst), .invert(invert), .in_valid(in_valid),
                      .in_data(in_data), .out_valid(out_valid), .out_data(out_data));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; in_valid = 1'b0;
    @(posedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic send(input logic signed [23:0] x);
    @(negedge clk); in_valid = 1'b1; in_data = x;
    @(posedge clk); @(negedge clk); in_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD*400000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();
    check("R1 out_valid", int'(out_valid), 0);
    check("R1 out_data", int'(out_data), 0);

    // R3 fixed-point recursion with R6 idle gaps between samples
    for (int i = 0; i < NVEC; i++) begin
      send(VEC_IN[i]);
      check("R2 strobe", int'(out_valid), 1);
      check("R3 value", int'(out_data), int'(VEC_EXP[i]));
      for (int g = 0; g < i; g++) begin
        @(negedge clk);
        check("R2 no strobe", int'(out_valid), 0);
        check("R6 held", int'(out_data), int'(VEC_EXP[i]));
      end
    end

    // R4 saturation at both rails
    do_reset();
    send(24'sd8388607);
    check("R4 top", int'(out_data), 8388607);
    send(-24'sd8388608);
    check("R4 bottom", int'(out_data), -8388608);

    // R5 inversion
    do_reset();
    invert = 1'b1;
    send(24'sd1000);
    check("R5 negate", int'(out_data), -1000);
    do_reset();
    send(-24'sd8388608);
    check("R5 negate min", int'(out_data), 8388607);
    invert = 1'b0;

    // R1 reset clears state: a fresh sample starts from zero history
    do_reset();
    send(24'sd500);
    check("R1 state cleared", int'(out_data), 500);

    // R7 settling of a held input, both signs
    do_reset();
    @(negedge clk); in_valid = 1'b1; in_data = 24'sd1000;
    repeat (20000) @(posedge clk);
    @(negedge clk); in_valid = 1'b0;
    check("R7 settle pos", int'((out_data >= -1) && (out_data <= 1)), 1);
    do_reset();
    @(negedge clk); in_valid = 1'b1; in_data = -24'sd1000;
    repeat (20000) @(posedge clk);
    @(negedge clk); in_valid = 1'b0;
    check("R7 settle neg", int'((out_data >= -1) && (out_data <= 1)), 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule